// File: doc/BRIEF.md
# Trace-Driven Core Request Emulator

This block replaces a detailed out-of-order core with a timing engine driven by a prepared trace. Each trace item is a group of micro-ops. The group carries its size in micro-ops, a weight in cycles, a backward distance to the group it depends on, and counts of instruction, load and store requests. The engine issues those requests to an uncore port, one per cycle, and takes completion responses back. It paces the groups the way a core would: instruction fetch comes first, loads go out while the group sits in the reorder window, and stores go out after commit.

An outside trace feeder presents groups on a valid/ready stream. The uncore, or a model of it, answers every request with a tagged response. The block exports a busy-cycle counter and a committed micro-op counter. These give the emulated run time and the throughput.

Top module: `trace_core_emu`

## Requirements
- R1: Out of reset, `node_ready_o` is 1, `req_valid_o` is 0, and both counters are 0.
- R2: A fetched group issues its instruction requests (type code 0) one at a time. Each request waits for its response before the next one is issued. The group enters the reorder window only when none are left. The node tag of an instruction request is the window slot that the group will occupy, and slots are handed out round-robin from 0.
- R3: The fetched group is admitted when two conditions hold: the summed size of the admitted but uncommitted groups is below `ROB_UOPS`, and fewer than `NODES` groups are held. Otherwise fetch stalls with the group held and `node_ready_o` low.
- R4: A group with parent distance d > 0 issues loads only after the group d positions older has no loads or stores left to issue or outstanding. A distance of 0 means no parent.
- R5: Outstanding load and store requests (type codes 1 and 2) together never exceed `DATA_SLOTS`. Data requests stop while the limit is reached.
- R6: At most one request is issued per cycle. The priority is load, then instruction, then store. Among eligible groups, the oldest uncommitted group issues its load first.
- R7: A group becomes ready W+1 cycles after the cycle in which its loads are all complete, or after it is admitted if it has no loads. A ready group commits only at the window head, one group per cycle, in trace order.
- R8: Stores are issued only by the oldest committed group that is still held. That group must already be committed.
- R9: A committed group releases its slot once its stores are done, one group per cycle, oldest first. A store-carrying group counts as finished for its dependants only after its stores complete.
- R10: `busy_cycles_o` counts the cycles in which a group is held anywhere. `committed_uops_o` adds the group size at each commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| node_valid_i | input | 1 | Trace group offered |
| node_ready_o | output | 1 | Fetch register empty, group taken |
| node_size_i | input | SIZE_W | Micro-op count of the group |
| node_weight_i | input | WT_W | Cycles from load completion to ready |
| node_parent_i | input | PAR_W | Distance back to the parent group, 0 for none |
| node_ninst_i | input | CNT_W | Instruction request count |
| node_nload_i | input | CNT_W | Load request count |
| node_nstore_i | input | CNT_W | Store request count |
| req_valid_o | output | 1 | Request issued this cycle |
| req_type_o | output | 2 | 0 instruction, 1 load, 2 store |
| req_node_o | output | log2(NODES) | Window slot tag |
| rsp_valid_i | input | 1 | Response arrives |
| rsp_type_i | input | 2 | Type of the completed request |
| rsp_node_i | input | log2(NODES) | Slot tag of the completed request |
| busy_cycles_o | output | CYC_W | Busy-cycle counter |
| committed_uops_o | output | CYC_W | Committed micro-op counter |

## Verification
Three things can fall in the same cycle: a load, an instruction request and a store can all become eligible together, and a load completion can arrive in the cycle that another load is issued to the same group. The bench provokes both with groups that carry fetch, load and store counts at once, while varying uncore latencies keep several requests in flight. A behavioural model built on queues predicts which request wins the port and where each group sits. Every clock edge is judged against the issued type, the tag, the ready flag and both counters.

// File: rtl/emu_pkg.sv
package emu_pkg;
  typedef enum logic [1:0] {
    REQ_INSTR = 2'd0,
    REQ_LOAD  = 2'd1,
    REQ_STORE = 2'd2
  } req_e;
endpackage

// File: rtl/emu_fetch.sv
module emu_fetch #(
  parameter int SIZE_W = 6,
  parameter int WT_W   = 6,
  parameter int CNT_W  = 3,
  parameter int PAR_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              node_valid_i,
  output logic              node_ready_o,
  input  logic [SIZE_W-1:0] node_size_i,
  input  logic [WT_W-1:0]   node_weight_i,
  input  logic [PAR_W-1:0]  node_parent_i,
  input  logic [CNT_W-1:0]  node_ninst_i,
  input  logic [CNT_W-1:0]  node_nload_i,
  input  logic [CNT_W-1:0]  node_nstore_i,
  input  logic              admit_i,
  input  logic              inst_gnt_i,
  input  logic              inst_rsp_i,
  output logic              inst_want_o,
  output logic              done_o,
  output logic [SIZE_W-1:0] size_o,
  output logic [WT_W-1:0]   weight_o,
  output logic [PAR_W-1:0]  parent_o,
  output logic [CNT_W-1:0]  nload_o,
  output logic [CNT_W-1:0]  nstore_o
);
  logic             f_vld, f_busy;
  logic [CNT_W-1:0] f_left;

  assign node_ready_o = !f_vld;
  assign inst_want_o  = f_vld && (f_left != '0) && !f_busy;
  assign done_o       = f_vld && (f_left == '0) && !f_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_vld    <= 1'b0;
      f_busy   <= 1'b0;
      f_left   <= '0;
      size_o   <= '0;
      weight_o <= '0;
      parent_o <= '0;
      nload_o  <= '0;
      nstore_o <= '0;
    end else if (!f_vld) begin
      if (node_valid_i) begin
        f_vld    <= 1'b1;
        f_busy   <= 1'b0;
        f_left   <= node_ninst_i;
        size_o   <= node_size_i;
        weight_o <= node_weight_i;
        parent_o <= node_parent_i;
        nload_o  <= node_nload_i;
        nstore_o <= node_nstore_i;
      end
    end else begin
      if (admit_i) f_vld <= 1'b0;
      if (inst_gnt_i) begin
        f_left <= f_left - CNT_W'(1);
        f_busy <= 1'b1;
      end else if (inst_rsp_i) begin
        f_busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/emu_nodebuf.sv
module emu_nodebuf import emu_pkg::*; #(
  parameter int NODES      = 8,
  parameter int ROB_UOPS   = 32,
  parameter int DATA_SLOTS = 4,
  parameter int SIZE_W     = 6,
  parameter int WT_W       = 6,
  parameter int CNT_W      = 3,
  parameter int PAR_W      = 3,
  localparam int IDX_W     = $clog2(NODES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              admit_i,
  input  logic [SIZE_W-1:0] adm_size_i,
  input  logic [WT_W-1:0]   adm_weight_i,
  input  logic [PAR_W-1:0]  adm_parent_i,
  input  logic [CNT_W-1:0]  adm_nload_i,
  input  logic [CNT_W-1:0]  adm_nstore_i,
  input  logic              ld_gnt_i,
  input  logic              st_gnt_i,
  input  logic              rsp_valid_i,
  input  logic [1:0]        rsp_type_i,
  input  logic [IDX_W-1:0]  rsp_node_i,
  output logic              ld_want_o,
  output logic [IDX_W-1:0]  ld_idx_o,
  output logic              st_want_o,
  output logic [IDX_W-1:0]  st_idx_o,
  output logic [IDX_W-1:0]  tail_o,
  output logic              can_admit_o,
  output logic              commit_o,
  output logic [SIZE_W-1:0] commit_size_o,
  output logic              busy_o
);
  localparam int DS_W  = $clog2(DATA_SLOTS + 1);
  localparam int UOP_W = $clog2(ROB_UOPS + (1 << SIZE_W) + 1);

  logic [IDX_W-1:0] sq_head, rob_head, tail;
  logic [IDX_W:0]   count;
  logic [UOP_W-1:0] rob_uops;
  logic [DS_W-1:0]  dout;

  logic [NODES-1:0] vld, com, lddone, alldone, parok, ldel;
  logic [SIZE_W-1:0] sz   [NODES];
  logic [WT_W-1:0]   wc   [NODES];
  logic [PAR_W-1:0]  par  [NODES];
  logic [CNT_W-1:0]  ldl  [NODES];
  logic [CNT_W-1:0]  ldo  [NODES];
  logic [CNT_W-1:0]  stl  [NODES];
  logic [CNT_W-1:0]  sto  [NODES];
  logic [IDX_W-1:0]  age  [NODES];
  logic [IDX_W-1:0]  pslot[NODES];

  logic data_ok, free_w, rsp_ld, rsp_st;

  assign data_ok = dout < DS_W'(DATA_SLOTS);
  assign rsp_ld  = rsp_valid_i && (rsp_type_i == REQ_LOAD);
  assign rsp_st  = rsp_valid_i && (rsp_type_i == REQ_STORE);

  always_comb begin
    for (int i = 0; i < NODES; i++) begin
      lddone[i]  = (ldl[i] == '0) && (ldo[i] == '0);
      alldone[i] = lddone[i] && (stl[i] == '0) && (sto[i] == '0);
    end
  end

  // parent older than the oldest held group has already drained
  always_comb begin
    for (int i = 0; i < NODES; i++) begin
      age[i]   = IDX_W'(i) - sq_head;
      pslot[i] = IDX_W'(i) - IDX_W'(par[i]);
      parok[i] = (par[i] == '0) || ((IDX_W+1)'(par[i]) > {1'b0, age[i]}) || alldone[pslot[i]];
      ldel[i]  = vld[i] && !com[i] && (ldl[i] != '0) && parok[i] && data_ok;
    end
  end

  always_comb begin
    ld_want_o = 1'b0;
    ld_idx_o  = rob_head;
    for (int k = 0; k < NODES; k++) begin
      if (!ld_want_o && ldel[rob_head + IDX_W'(k)]) begin
        ld_want_o = 1'b1;
        ld_idx_o  = rob_head + IDX_W'(k);
      end
    end
  end

  assign st_idx_o      = sq_head;
  assign st_want_o     = vld[sq_head] && com[sq_head] && (stl[sq_head] != '0) && data_ok;
  assign free_w        = vld[sq_head] && com[sq_head] && (stl[sq_head] == '0) && (sto[sq_head] == '0);
  assign commit_o      = vld[rob_head] && !com[rob_head] && lddone[rob_head] && (wc[rob_head] == '0);
  assign commit_size_o = sz[rob_head];
  assign tail_o        = tail;
  assign can_admit_o   = (count < (IDX_W+1)'(NODES)) && (rob_uops < UOP_W'(ROB_UOPS));
  assign busy_o        = (count != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld <= '0;
      com <= '0;
      for (int i = 0; i < NODES; i++) begin
        sz[i]  <= '0;
        wc[i]  <= '0;
        par[i] <= '0;
        ldl[i] <= '0;
        ldo[i] <= '0;
        stl[i] <= '0;
        sto[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NODES; i++) begin
        if (admit_i && (tail == IDX_W'(i))) begin
          vld[i] <= 1'b1;
          com[i] <= 1'b0;
          sz[i]  <= adm_size_i;
          wc[i]  <= adm_weight_i;
          par[i] <= adm_parent_i;
          ldl[i] <= adm_nload_i;
          ldo[i] <= '0;
          stl[i] <= adm_nstore_i;
          sto[i] <= '0;
        end else begin
          if (free_w && (sq_head == IDX_W'(i))) vld[i] <= 1'b0;
          if (commit_o && (rob_head == IDX_W'(i))) com[i] <= 1'b1;
          if (vld[i] && !com[i] && lddone[i] && (wc[i] != '0)) wc[i] <= wc[i] - WT_W'(1);
          ldl[i] <= ldl[i] - CNT_W'(ld_gnt_i && (ld_idx_o == IDX_W'(i)));
          ldo[i] <= ldo[i] + CNT_W'(ld_gnt_i && (ld_idx_o == IDX_W'(i)))
                           - CNT_W'(rsp_ld && (rsp_node_i == IDX_W'(i)));
          stl[i] <= stl[i] - CNT_W'(st_gnt_i && (sq_head == IDX_W'(i)));
          sto[i] <= sto[i] + CNT_W'(st_gnt_i && (sq_head == IDX_W'(i)))
                           - CNT_W'(rsp_st && (rsp_node_i == IDX_W'(i)));
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_head  <= '0;
      rob_head <= '0;
      tail     <= '0;
      count    <= '0;
      rob_uops <= '0;
      dout     <= '0;
    end else begin
      sq_head  <= sq_head + IDX_W'(free_w);
      rob_head <= rob_head + IDX_W'(commit_o);
      tail     <= tail + IDX_W'(admit_i);
      count    <= count + (IDX_W+1)'(admit_i) - (IDX_W+1)'(free_w);
      rob_uops <= rob_uops + (admit_i ? UOP_W'(adm_size_i) : '0)
                           - (commit_o ? UOP_W'(sz[rob_head]) : '0);
      dout     <= dout + DS_W'(ld_gnt_i || st_gnt_i) - DS_W'(rsp_ld || rsp_st);
    end
  end
endmodule

// File: rtl/emu_arb.sv
module emu_arb import emu_pkg::*; (
  input  logic ld_want_i,
  input  logic inst_want_i,
  input  logic st_want_i,
  output logic ld_gnt_o,
  output logic inst_gnt_o,
  output logic st_gnt_o,
  output logic valid_o,
  output req_e type_o
);
  assign ld_gnt_o   = ld_want_i;
  assign inst_gnt_o = inst_want_i && !ld_want_i;
  assign st_gnt_o   = st_want_i && !ld_want_i && !inst_want_i;
  assign valid_o    = ld_want_i || inst_want_i || st_want_i;

  always_comb begin
    if (ld_want_i)        type_o = REQ_LOAD;
    else if (inst_want_i) type_o = REQ_INSTR;
    else                  type_o = REQ_STORE;
  end
endmodule

// File: rtl/trace_core_emu.sv
module trace_core_emu import emu_pkg::*; #(
  parameter int NODES      = 8,
  parameter int ROB_UOPS   = 32,
  parameter int DATA_SLOTS = 4,
  parameter int SIZE_W     = 6,
  parameter int WT_W       = 6,
  parameter int CNT_W      = 3,
  parameter int PAR_W      = 3,
  parameter int CYC_W      = 32,
  localparam int IDX_W     = $clog2(NODES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              node_valid_i,
  output logic              node_ready_o,
  input  logic [SIZE_W-1:0] node_size_i,
  input  logic [WT_W-1:0]   node_weight_i,
  input  logic [PAR_W-1:0]  node_parent_i,
  input  logic [CNT_W-1:0]  node_ninst_i,
  input  logic [CNT_W-1:0]  node_nload_i,
  input  logic [CNT_W-1:0]  node_nstore_i,
  output logic              req_valid_o,
  output logic [1:0]        req_type_o,
  output logic [IDX_W-1:0]  req_node_o,
  input  logic              rsp_valid_i,
  input  logic [1:0]        rsp_type_i,
  input  logic [IDX_W-1:0]  rsp_node_i,
  output logic [CYC_W-1:0]  busy_cycles_o,
  output logic [CYC_W-1:0]  committed_uops_o
);
  logic              f_done, inst_want, admit;
  logic [SIZE_W-1:0] f_size;
  logic [WT_W-1:0]   f_wt;
  logic [PAR_W-1:0]  f_par;
  logic [CNT_W-1:0]  f_nl, f_ns;
  logic              ld_want, st_want, can_admit, commit, buf_busy;
  logic [IDX_W-1:0]  ld_idx, st_idx, tail;
  logic [SIZE_W-1:0] commit_size;
  logic              ld_gnt, inst_gnt, st_gnt;
  req_e              req_type;
  logic              inst_rsp;

  assign inst_rsp = rsp_valid_i && (rsp_type_i == REQ_INSTR);
  assign admit    = f_done && can_admit;

  emu_fetch #(.SIZE_W(SIZE_W), .WT_W(WT_W), .CNT_W(CNT_W), .PAR_W(PAR_W)) u_fetch (
    .clk_i, .rst_ni,
    .node_valid_i, .node_ready_o,
    .node_size_i, .node_weight_i, .node_parent_i,
    .node_ninst_i, .node_nload_i, .node_nstore_i,
    .admit_i(admit), .inst_gnt_i(inst_gnt), .inst_rsp_i(inst_rsp),
    .inst_want_o(inst_want), .done_o(f_done),
    .size_o(f_size), .weight_o(f_wt), .parent_o(f_par),
    .nload_o(f_nl), .nstore_o(f_ns)
  );

  emu_nodebuf #(
    .NODES(NODES), .ROB_UOPS(ROB_UOPS), .DATA_SLOTS(DATA_SLOTS),
    .SIZE_W(SIZE_W), .WT_W(WT_W), .CNT_W(CNT_W), .PAR_W(PAR_W)
  ) u_buf (
    .clk_i, .rst_ni,
    .admit_i(admit), .adm_size_i(f_size), .adm_weight_i(f_wt),
    .adm_parent_i(f_par), .adm_nload_i(f_nl), .adm_nstore_i(f_ns),
    .ld_gnt_i(ld_gnt), .st_gnt_i(st_gnt),
    .rsp_valid_i, .rsp_type_i, .rsp_node_i,
    .ld_want_o(ld_want), .ld_idx_o(ld_idx),
    .st_want_o(st_want), .st_idx_o(st_idx),
    .tail_o(tail), .can_admit_o(can_admit),
    .commit_o(commit), .commit_size_o(commit_size), .busy_o(buf_busy)
  );

  emu_arb u_arb (
    .ld_want_i(ld_want), .inst_want_i(inst_want), .st_want_i(st_want),
    .ld_gnt_o(ld_gnt), .inst_gnt_o(inst_gnt), .st_gnt_o(st_gnt),
    .valid_o(req_valid_o), .type_o(req_type)
  );

  assign req_type_o = req_type;
  assign req_node_o = ld_gnt ? ld_idx : (inst_gnt ? tail : st_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_cycles_o    <= '0;
      committed_uops_o <= '0;
    end else begin
      busy_cycles_o    <= busy_cycles_o + CYC_W'(!node_ready_o || buf_busy);
      committed_uops_o <= committed_uops_o + (commit ? CYC_W'(commit_size) : '0);
    end
  end
endmodule

// File: rtl/emu_core_chk.sv
module emu_core_chk import emu_pkg::*; #(
  parameter int DATA_SLOTS = 4,
  parameter int CYC_W      = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_o,
  input logic [1:0]       req_type_o,
  input logic             rsp_valid_i,
  input logic [1:0]       rsp_type_i,
  input logic [CYC_W-1:0] busy_cycles_o,
  input logic [CYC_W-1:0] committed_uops_o
);
  logic [7:0] dcnt, icnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dcnt <= '0;
      icnt <= '0;
    end else begin
      dcnt <= dcnt + 8'(req_valid_o && (req_type_o != REQ_INSTR))
                   - 8'(rsp_valid_i && (rsp_type_i != REQ_INSTR));
      icnt <= icnt + 8'(req_valid_o && (req_type_o == REQ_INSTR))
                   - 8'(rsp_valid_i && (rsp_type_i == REQ_INSTR));
    end
  end

  AST_DATA_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dcnt <= 8'(DATA_SLOTS)); // R5
  AST_INST_SERIAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && (req_type_o == REQ_INSTR)) |-> (icnt == 8'd0)); // R2
  AST_BUSY_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_cycles_o == $past(busy_cycles_o)) || (busy_cycles_o == $past(busy_cycles_o) + CYC_W'(1))); // R10
  AST_COMMIT_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    committed_uops_o >= $past(committed_uops_o)); // R10
endmodule

bind trace_core_emu emu_core_chk #(.DATA_SLOTS(DATA_SLOTS), .CYC_W(CYC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .req_valid_o(req_valid_o), .req_type_o(req_type_o),
  .rsp_valid_i(rsp_valid_i), .rsp_type_i(rsp_type_i),
  .busy_cycles_o(busy_cycles_o), .committed_uops_o(committed_uops_o)
);

// File: tb/sim_trace_core_emu.sv
`timescale 1ns/1ps
module sim_trace_core_emu;
  localparam int N  = 8;
  localparam int RU = 32;
  localparam int DS = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic       node_valid_i = 1'b0;
  logic       node_ready_o;
  logic [5:0] node_size_i = '0;
  logic [5:0] node_weight_i = '0;
  logic [2:0] node_parent_i = '0;
  logic [2:0] node_ninst_i = '0, node_nload_i = '0, node_nstore_i = '0;
  logic       req_valid_o;
  logic [1:0] req_type_o;
  logic [2:0] req_node_o;
  logic       rsp_valid_i = 1'b0;
  logic [1:0] rsp_type_i = '0;
  logic [2:0] rsp_node_i = '0;
  logic [31:0] busy_cycles_o, committed_uops_o;

  trace_core_emu #(.NODES(N), .ROB_UOPS(RU), .DATA_SLOTS(DS)) u0 (
    .clk_i(clk), .rst_ni,
    .node_valid_i, .node_ready_o, .node_size_i, .node_weight_i, .node_parent_i,
    .node_ninst_i, .node_nload_i, .node_nstore_i,
    .req_valid_o, .req_type_o, .req_node_o,
    .rsp_valid_i, .rsp_type_i, .rsp_node_i,
    .busy_cycles_o, .committed_uops_o
  );

  int checks = 0, errors = 0;
  bit done_all = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  typedef struct {int seq, size, wt, par, ldl, ldo, stl, sto, wc;} mnode_t;
  typedef struct {int due, typ, node;} pend_t;

  mnode_t rob_q[$];
  mnode_t ret_q[$];
  pend_t  pend[$];
  bit     mdone [0:1023];
  int admitted = 0, ruops = 0, mdout = 0, mbusy = 0, mcom = 0, cyc = 0, reqcnt = 0;
  bit fv = 0, fbusy = 0;
  int fsize, fwt, fpar, fnl, fns, fleft;

  int tr_size[64], tr_wt[64], tr_par[64], tr_ni[64], tr_nl[64], tr_ns[64];
  int tr_n = 0, tr_pos = 0, total_size = 0;

  task automatic add_node(int s, int w, int p, int ni, int nl, int ns);
    tr_size[tr_n] = s; tr_wt[tr_n] = w; tr_par[tr_n] = p;
    tr_ni[tr_n] = ni; tr_nl[tr_n] = nl; tr_ns[tr_n] = ns;
    tr_n++;
    total_size += s;
  endtask

  function automatic bit parent_ok(mnode_t e);
    if (e.par == 0 || e.seq - e.par < 0) return 1;
    return mdone[e.seq - e.par];
  endfunction

  task automatic step(string tag);
    int li, etype, enode, lat;
    bit ev, iw, sw, commit_f, free_f, admit_f, busy_pre, drv;
    mnode_t t;
    @(negedge clk);
    cyc++;
    foreach (rob_q[i]) mdone[rob_q[i].seq] = (rob_q[i].ldl == 0 && rob_q[i].ldo == 0 && rob_q[i].stl == 0 && rob_q[i].sto == 0);
    foreach (ret_q[i]) mdone[ret_q[i].seq] = (ret_q[i].stl == 0 && ret_q[i].sto == 0);
    li = -1;
    foreach (rob_q[i])
      if (li < 0 && rob_q[i].ldl > 0 && parent_ok(rob_q[i]) && mdout < DS) li = i;
    iw = fv && fleft > 0 && !fbusy;
    sw = ret_q.size() > 0 && ret_q[0].stl > 0 && mdout < DS;
    ev = (li >= 0) || iw || sw;
    etype = 0; enode = 0;
    if (li >= 0)  begin etype = 1; enode = rob_q[li].seq % N; end
    else if (iw)  begin etype = 0; enode = admitted % N; end
    else if (sw)  begin etype = 2; enode = ret_q[0].seq % N; end
    // R3: ready tracks the held fetch group; R6 priority seen through type/tag
    chk(node_ready_o == !fv, tag, "node_ready_o", node_ready_o, !fv);
    chk(req_valid_o == ev, tag, "req_valid_o", req_valid_o, ev);
    if (ev && req_valid_o) begin
      chk(req_type_o == 2'(etype), tag, "req_type_o", req_type_o, etype);
      chk(req_node_o == 3'(enode), tag, "req_node_o", req_node_o, enode);
    end
    chk(busy_cycles_o == 32'(mbusy), "R10", "busy_cycles_o", busy_cycles_o, mbusy);
    chk(committed_uops_o == 32'(mcom), "R10", "committed_uops_o", committed_uops_o, mcom);
    // R5: data requests in flight stay within the slot limit
    chk(mdout <= DS, "R5", "data in flight", mdout, DS);

    drv = (tr_pos < tr_n) && !fv;
    node_valid_i = drv;
    if (drv) begin
      node_size_i = 6'(tr_size[tr_pos]); node_weight_i = 6'(tr_wt[tr_pos]);
      node_parent_i = 3'(tr_par[tr_pos]); node_ninst_i = 3'(tr_ni[tr_pos]);
      node_nload_i = 3'(tr_nl[tr_pos]); node_nstore_i = 3'(tr_ns[tr_pos]);
    end
    rsp_valid_i = 1'b0;
    if (pend.size() > 0 && pend[0].due <= cyc) begin
      rsp_valid_i = 1'b1;
      rsp_type_i = 2'(pend[0].typ);
      rsp_node_i = 3'(pend[0].node);
    end
    if (ev) begin
      lat = (etype == 0) ? 2 : (etype == 1) ? 3 + reqcnt % 4 : 4 + reqcnt % 3;
      pend.push_back('{cyc + lat, etype, enode});
      reqcnt++;
    end

    busy_pre = fv || rob_q.size() > 0 || ret_q.size() > 0;
    commit_f = rob_q.size() > 0 && rob_q[0].ldl == 0 && rob_q[0].ldo == 0 && rob_q[0].wc == 0;
    free_f   = ret_q.size() > 0 && ret_q[0].stl == 0 && ret_q[0].sto == 0;
    admit_f  = fv && fleft == 0 && !fbusy && ruops < RU && (rob_q.size() + ret_q.size()) < N;

    foreach (rob_q[i]) if (rob_q[i].ldl == 0 && rob_q[i].ldo == 0 && rob_q[i].wc > 0) begin
      t = rob_q[i]; t.wc--; rob_q[i] = t;
    end
    if (li >= 0) begin t = rob_q[li]; t.ldl--; t.ldo++; rob_q[li] = t; mdout++; end
    else if (!iw && sw) begin t = ret_q[0]; t.stl--; t.sto++; ret_q[0] = t; mdout++; end
    if (rsp_valid_i) begin
      if (pend[0].typ == 0) fbusy = 0;
      else if (pend[0].typ == 1) begin
        foreach (rob_q[i]) if (rob_q[i].seq % N == pend[0].node) begin
          t = rob_q[i]; t.ldo--; rob_q[i] = t;
        end
        mdout--;
      end else begin
        foreach (ret_q[i]) if (ret_q[i].seq % N == pend[0].node) begin
          t = ret_q[i]; t.sto--; ret_q[i] = t;
        end
        mdout--;
      end
      void'(pend.pop_front());
    end
    if (free_f) void'(ret_q.pop_front());
    if (commit_f) begin
      t = rob_q.pop_front();
      ruops -= t.size; mcom += t.size;
      ret_q.push_back(t);
    end
    if (admit_f) begin
      t = '{admitted, fsize, fwt, fpar, fnl, 0, fns, 0, fwt};
      mdone[admitted] = 0;
      rob_q.push_back(t);
      admitted++; ruops += fsize; fv = 0;
    end else if (fv && iw && li < 0) begin
      fleft--; fbusy = 1;
    end
    if (drv) begin
      fv = 1; fbusy = 0;
      fsize = tr_size[tr_pos]; fwt = tr_wt[tr_pos]; fpar = tr_par[tr_pos];
      fnl = tr_nl[tr_pos]; fns = tr_ns[tr_pos]; fleft = tr_ni[tr_pos];
      tr_pos++;
    end
    if (busy_pre) mbusy++;
  endtask

  task automatic run(string tag);
    int guard = 0;
    tr_pos = 0;
    while (!(tr_pos == tr_n && !fv && rob_q.size() == 0 && ret_q.size() == 0 && pend.size() == 0)) begin
      step(tag);
      guard++;
      if (guard > 5000) begin
        chk(0, tag, "scenario watchdog", guard, 5000);
        break;
      end
    end
    step(tag);
    node_valid_i = 1'b0;
    tr_n = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1: reset state before the first active edge
    chk(node_ready_o == 1'b1, "R1", "node_ready_o", node_ready_o, 1);
    chk(req_valid_o == 1'b0, "R1", "req_valid_o", req_valid_o, 0);
    chk(busy_cycles_o == 0, "R1", "busy_cycles_o", busy_cycles_o, 0);
    chk(committed_uops_o == 0, "R1", "committed_uops_o", committed_uops_o, 0);

    // R7: request-free groups, weight paced, in-order commit
    for (int i = 0; i < 6; i++) add_node(3, (5 - i) * 2, 0, 0, 0, 0);
    run("R7");
    // R2: serial instruction fetch before admission
    for (int i = 0; i < 5; i++) add_node(4, 1, 0, i % 3 + 1, 0, 0);
    run("R2");
    // R3: large groups exhaust micro-op occupancy
    for (int i = 0; i < 6; i++) add_node(20, 3, 0, 0, 1, 0);
    run("R3");
    // R4: parent chains gate load issue
    for (int i = 0; i < 8; i++) add_node(2, 1, (i % 2) + 1, 0, 2, 0);
    run("R4");
    // R5/R6: saturate data slots with fetch, load and store all eligible
    for (int i = 0; i < 8; i++) add_node(3, 0, 0, 1, 5, 1);
    run("R5/R6");
    // R8 and R9: post-commit stores, store-gated dependants
    for (int i = 0; i < 8; i++) add_node(2, 2, (i % 3 == 0) ? 1 : 0, 0, i % 2, 3);
    run("R8/R9");
    // R6 again with mixed traffic
    for (int i = 0; i < 10; i++) add_node(i + 1, i % 4, i % 3, i % 2, (i * 3) % 6, i % 3);
    run("R6");

    // R10: final totals against the trace
    chk(committed_uops_o == 32'(total_size), "R10", "final committed", committed_uops_o, total_size);
    chk(busy_cycles_o > 0, "R10", "busy nonzero", busy_cycles_o, 1);
    done_all = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_all) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 150000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule